// File: doc/BRIEF.md
# Partial-Sum Output Tile Swapper

In a tiled convolution the output partial sums live in two local banks. While the arithmetic keeps accumulating into one bank over the input-channel tiles, this block services the other bank. Each step has two phases, always in this order. First it drains the finished tile from the idle bank into the layer output memory. Then it refills that bank with the stored partial sums of the next output tile, so they can keep accumulating later. One select bit, which flips at every accepted start, tells both sides which bank is being swapped. The arithmetic side uses the opposite bank.

The store and reload work runs alongside the compute loop. The step time is therefore set by whichever of the two takes longer. The first step has nothing to write back and sets `skip_store`. The last step has nothing to refill and sets `skip_load`. A final store-only step flushes the last computed tile.

Words are moved with the map index outermost, then the row, then the column. Both layer-memory request channels use valid/ready. A raised valid holds its address and data steady until ready is seen, and ready may drop in any cycle. Read responses have no back-pressure, because each response goes straight into the bank through its dedicated write port. The local bank is a synchronous RAM with one cycle of read latency.

Top module: `psum_tile_swapper`

## Requirements
- R1: While reset is asserted, `done`, `work_bank`, `mem_wr_valid`, `mem_rd_valid`, `bank_rd_en` and `bank_wr_en` are all 0.
- R2: A `start` seen while idle inverts `work_bank`. `work_bank` then stays constant until the step ends. A `start` raised during a step is ignored: it neither toggles the bank nor queues another step.
- R3: The store phase reads every word of the work bank once. The bank address is the concatenation {map, row, col}: col in the low bits, row above it, map on top, each field ceil(log2(count)) bits wide. Word (m, r, c) is written to layer address `store_base + m*ROWS*COLS + r*COLS + c`, in the order map outermost, then row, then column.
- R4: The reload phase requests layer address `load_base + m*ROWS*COLS + r*COLS + c` in the same order. It writes the responses, in arrival order, to the packed bank address of the matching word.
- R5: No reload request is raised before the last store write has been accepted.
- R6: With `skip_store` set, no store write or bank read takes place. With `skip_load` set, no read request or bank write takes place, and the bank keeps its contents.
- R7: `done` is a one-cycle pulse. It comes in the cycle after the final reload bank write. If the reload is skipped, it comes in the cycle after the final store write is accepted. If both phases are skipped, it comes in the cycle after `start`.
- R8: On both layer-memory request channels, a valid that is not accepted stays high, with unchanged address and data, in the next cycle.
- R9: With ready held high, a reload-only step raises `done` WORDS+2 cycles after `start`, and a store-only step raises it 2*WORDS+2 cycles after `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a step (taken only while idle) |
| skip_store | input | 1 | Omit the write-back phase of this step |
| skip_load | input | 1 | Omit the reload phase of this step |
| store_base | input | MAW | Layer address of the tile being written back |
| load_base | input | MAW | Layer address of the tile being reloaded |
| done | output | 1 | One-cycle step completion pulse |
| work_bank | output | 1 | Bank being swapped; compute uses the other |
| mem_wr_valid | output | 1 | Layer write request valid |
| mem_wr_ready | input | 1 | Layer write request accepted |
| mem_wr_addr | output | MAW | Layer write address |
| mem_wr_data | output | DW | Layer write data |
| mem_rd_valid | output | 1 | Layer read request valid |
| mem_rd_ready | input | 1 | Layer read request accepted |
| mem_rd_addr | output | MAW | Layer read address |
| mem_rsp_valid | input | 1 | Layer read response valid |
| mem_rsp_data | input | DW | Layer read response data |
| bank_rd_en | output | 1 | Work bank read enable |
| bank_rd_addr | output | MW+RW+CW | Packed {map,row,col} read address |
| bank_rd_data | input | DW | Work bank read data, one cycle after enable |
| bank_wr_en | output | 1 | Work bank write enable |
| bank_wr_addr | output | MW+RW+CW | Packed {map,row,col} write address |
| bank_wr_data | output | DW | Work bank write data |

## Verification
Each result has a fixed cycle at which it is due:
- `done` must appear exactly one cycle after the last bank write, after the last accepted store write, or after `start`, depending on which phases run.
- With ready held high, a reload-only step ends WORDS+2 cycles after `start`.
- A store-only step ends 2*WORDS+2 cycles after `start`, because each stored word takes one bank read cycle and one cycle on the write channel.

The bench counts clock edges and samples every output at the falling edge. It logs the cycle of each handshake, bank write and `done`, and compares them with these offsets. The data, addresses and order are checked word by word as each handshake happens. The contents of the layer memory and the banks are checked once each step is over.

// File: rtl/psum_swap_pkg.sv
package psum_swap_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_STORE = 2'd1,
    PH_LOAD  = 2'd2,
    PH_DONE  = 2'd3
  } swap_phase_t;

  // Width of an index field able to hold 0..n-1 (at least one bit).
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/psum_tile_walker.sv
module psum_tile_walker import psum_swap_pkg::*; #(
  parameter int unsigned MAPS = 3,
  parameter int unsigned ROWS = 10,
  parameter int unsigned COLS = 20,
  localparam int unsigned MW  = idx_bits(MAPS),
  localparam int unsigned RW  = idx_bits(ROWS),
  localparam int unsigned CW  = idx_bits(COLS),
  localparam int unsigned BAW = MW + RW + CW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           adv,
  output logic [BAW-1:0] idx_o,
  output logic           last_o
);

  logic [MW-1:0] map_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic          col_end, row_end, map_end;

  assign col_end = (col_q == CW'(COLS - 1));
  assign row_end = (row_q == RW'(ROWS - 1));
  assign map_end = (map_q == MW'(MAPS - 1));

  // Column fastest, map slowest.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
      row_q <= '0;
      col_q <= '0;
    end else if (clear) begin
      map_q <= '0;
      row_q <= '0;
      col_q <= '0;
    end else if (adv) begin
      if (!col_end) begin
        col_q <= col_q + 1'b1;
      end else begin
        col_q <= '0;
        if (!row_end) begin
          row_q <= row_q + 1'b1;
        end else begin
          row_q <= '0;
          map_q <= map_end ? '0 : map_q + 1'b1;
        end
      end
    end
  end

  assign idx_o  = {map_q, row_q, col_q};
  assign last_o = col_end && row_end && map_end;

endmodule

// File: rtl/psum_tile_swapper.sv
module psum_tile_swapper import psum_swap_pkg::*; #(
  parameter int unsigned DW   = 16,
  parameter int unsigned MAPS = 3,
  parameter int unsigned ROWS = 10,
  parameter int unsigned COLS = 20,
  parameter int unsigned MAW  = 16,
  localparam int unsigned MW  = idx_bits(MAPS),
  localparam int unsigned RW  = idx_bits(ROWS),
  localparam int unsigned CW  = idx_bits(COLS),
  localparam int unsigned BAW = MW + RW + CW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           skip_store,
  input  logic           skip_load,
  input  logic [MAW-1:0] store_base,
  input  logic [MAW-1:0] load_base,
  output logic           done,
  output logic           work_bank,
  output logic           mem_wr_valid,
  input  logic           mem_wr_ready,
  output logic [MAW-1:0] mem_wr_addr,
  output logic [DW-1:0]  mem_wr_data,
  output logic           mem_rd_valid,
  input  logic           mem_rd_ready,
  output logic [MAW-1:0] mem_rd_addr,
  input  logic           mem_rsp_valid,
  input  logic [DW-1:0]  mem_rsp_data,
  output logic           bank_rd_en,
  output logic [BAW-1:0] bank_rd_addr,
  input  logic [DW-1:0]  bank_rd_data,
  output logic           bank_wr_en,
  output logic [BAW-1:0] bank_wr_addr,
  output logic [DW-1:0]  bank_wr_data
);

  localparam int unsigned PLANE = ROWS * COLS;

  // Linear offset of a packed {map,row,col} index inside the tile.
  function automatic logic [MAW-1:0] tile_offset(input logic [BAW-1:0] pk);
    logic [MAW-1:0] m, r, c;
    m = MAW'(pk[BAW-1 -: MW]);
    r = MAW'(pk[CW +: RW]);
    c = MAW'(pk[CW-1:0]);
    return m * MAW'(PLANE) + r * MAW'(COLS) + c;
  endfunction

  swap_phase_t    phase_q;
  logic           sel_q, load_en_q;
  logic [MAW-1:0] st_base_q, ld_base_q;
  logic           accept;

  assign accept = (phase_q == PH_IDLE) && start;

  // ---------------- store path: bank -> layer memory ----------------
  logic           st_issued_q, rd_pend_q, pend_last_q;
  logic           wr_valid_q, wr_last_q;
  logic [MAW-1:0] pend_addr_q, wr_addr_q;
  logic [DW-1:0]  wr_data_q;
  logic [BAW-1:0] sw_idx;
  logic           sw_last, st_fin;

  psum_tile_walker #(.MAPS(MAPS), .ROWS(ROWS), .COLS(COLS)) u_store_walk (
    .clk(clk), .rst_n(rst_n), .clear(accept), .adv(bank_rd_en),
    .idx_o(sw_idx), .last_o(sw_last)
  );

  // A read is issued only when its word can land in an empty holding slot.
  assign bank_rd_en   = (phase_q == PH_STORE) && !st_issued_q && !rd_pend_q &&
                        (!wr_valid_q || mem_wr_ready);
  assign bank_rd_addr = sw_idx;
  assign st_fin       = wr_valid_q && mem_wr_ready && wr_last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_issued_q <= 1'b0;
      rd_pend_q   <= 1'b0;
      pend_last_q <= 1'b0;
      pend_addr_q <= '0;
      wr_valid_q  <= 1'b0;
      wr_last_q   <= 1'b0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
    end else begin
      if (accept)                    st_issued_q <= 1'b0;
      else if (bank_rd_en && sw_last) st_issued_q <= 1'b1;
      rd_pend_q <= bank_rd_en;
      if (bank_rd_en) begin
        pend_last_q <= sw_last;
        pend_addr_q <= st_base_q + tile_offset(sw_idx);
      end
      if (rd_pend_q) begin
        wr_valid_q <= 1'b1;
        wr_data_q  <= bank_rd_data;
        wr_addr_q  <= pend_addr_q;
        wr_last_q  <= pend_last_q;
      end else if (mem_wr_ready) begin
        wr_valid_q <= 1'b0;
      end
    end
  end

  assign mem_wr_valid = wr_valid_q;
  assign mem_wr_addr  = wr_addr_q;
  assign mem_wr_data  = wr_data_q;

  // ---------------- reload path: layer memory -> bank ----------------
  logic           rq_issued_q, rq_adv, rq_last, rs_last, ld_fin;
  logic [BAW-1:0] rq_idx, rs_idx;

  psum_tile_walker #(.MAPS(MAPS), .ROWS(ROWS), .COLS(COLS)) u_req_walk (
    .clk(clk), .rst_n(rst_n), .clear(accept), .adv(rq_adv),
    .idx_o(rq_idx), .last_o(rq_last)
  );

  psum_tile_walker #(.MAPS(MAPS), .ROWS(ROWS), .COLS(COLS)) u_rsp_walk (
    .clk(clk), .rst_n(rst_n), .clear(accept), .adv(bank_wr_en),
    .idx_o(rs_idx), .last_o(rs_last)
  );

  assign mem_rd_valid = (phase_q == PH_LOAD) && !rq_issued_q;
  assign mem_rd_addr  = ld_base_q + tile_offset(rq_idx);
  assign rq_adv       = mem_rd_valid && mem_rd_ready;
  assign bank_wr_en   = (phase_q == PH_LOAD) && mem_rsp_valid;
  assign bank_wr_addr = rs_idx;
  assign bank_wr_data = mem_rsp_data;
  assign ld_fin       = bank_wr_en && rs_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rq_issued_q <= 1'b0;
    else if (accept)            rq_issued_q <= 1'b0;
    else if (rq_adv && rq_last) rq_issued_q <= 1'b1;
  end

  // ---------------- step sequencing ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      sel_q     <= 1'b0;
      load_en_q <= 1'b0;
      st_base_q <= '0;
      ld_base_q <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start) begin
          sel_q     <= ~sel_q;
          st_base_q <= store_base;
          ld_base_q <= load_base;
          load_en_q <= !skip_load;
          phase_q   <= !skip_store ? PH_STORE : (!skip_load ? PH_LOAD : PH_DONE);
        end
        PH_STORE: if (st_fin) phase_q <= load_en_q ? PH_LOAD : PH_DONE;
        PH_LOAD:  if (ld_fin) phase_q <= PH_DONE;
        PH_DONE:  phase_q <= PH_IDLE;
        default:  phase_q <= PH_IDLE;
      endcase
    end
  end

  assign done      = (phase_q == PH_DONE);
  assign work_bank = sel_q;

  // ---------------- assertions ----------------
  assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  assert_store_before_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !mem_wr_valid && !bank_rd_en);

  assert_bank_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> $stable(work_bank));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && load_en_q |-> $past(bank_wr_en));

  assert_no_load_skipped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en_q |-> !mem_rd_valid && !bank_wr_en);

  assert_rsp_behind_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr_en |-> rq_issued_q || (tile_offset(rs_idx) < tile_offset(rq_idx)));

endmodule

// File: tb/psum_tile_swapper_bench.sv
`timescale 1ns/1ps
module psum_tile_swapper_bench;

  localparam int MAPS = 2;
  localparam int ROWS = 3;
  localparam int COLS = 4;
  localparam int N    = MAPS * ROWS * COLS;
  localparam int DW   = 16;
  localparam int MAW  = 8;
  localparam int BAW  = 5;

  logic clk, rst_n;
  logic start, skip_store, skip_load;
  logic [MAW-1:0] store_base, load_base;
  logic done, work_bank;
  logic mem_wr_valid, mem_wr_ready;
  logic [MAW-1:0] mem_wr_addr;
  logic [DW-1:0]  mem_wr_data;
  logic mem_rd_valid, mem_rd_ready;
  logic [MAW-1:0] mem_rd_addr;
  logic mem_rsp_valid;
  logic [DW-1:0]  mem_rsp_data;
  logic bank_rd_en, bank_wr_en;
  logic [BAW-1:0] bank_rd_addr, bank_wr_addr;
  logic [DW-1:0]  bank_rd_data, bank_wr_data;

  psum_tile_swapper #(.DW(DW), .MAPS(MAPS), .ROWS(ROWS), .COLS(COLS), .MAW(MAW)) u_psum_tile_swapper (
    .clk(clk), .rst_n(rst_n), .start(start), .skip_store(skip_store), .skip_load(skip_load),
    .store_base(store_base), .load_base(load_base), .done(done), .work_bank(work_bank),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .bank_rd_en(bank_rd_en), .bank_rd_addr(bank_rd_addr), .bank_rd_data(bank_rd_data),
    .bank_wr_en(bank_wr_en), .bank_wr_addr(bank_wr_addr), .bank_wr_data(bank_wr_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int wr_cnt, rd_cnt, bwr_cnt, done_cnt, done_cyc, last_bwr_cyc, last_wacc_cyc;
  int cur_sb, cur_lb, kind, exp_wr;
  bit fast_mode = 1'b1;
  bit fill_now = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic [DW-1:0] lmem [256];
  logic [DW-1:0] bmem [2][32];

  function automatic logic [15:0] fval(input int a);
    return 16'(a * 37 + 5);
  endfunction
  function automatic logic [15:0] hval(input int l);
    return 16'(40960 + l * 3);
  endfunction
  // Packed bank address: map in bit 4, row in bits 3:2, col in bits 1:0.
  function automatic int packi(input int l);
    return ((l / (ROWS * COLS)) << 4) | (((l / COLS) % ROWS) << 2) | (l % COLS);
  endfunction
  function automatic logic [15:0] store_exp(input int l);
    case (kind)
      0:       return hval(l);
      1:       return fval(l);
      default: return fval(24 + l);
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Ready patterns, changed shortly after each rising edge.
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_wr_ready = fast_mode ? 1'b1 : lfsr[0];
    mem_rd_ready = fast_mode ? 1'b1 : lfsr[3];
  end

  // Layer memory (one-cycle read response) and the two local banks.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < 256; a++) lmem[a] <= fval(a);
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < 32; i++) bmem[b][i] <= '0;
      mem_rsp_valid <= 1'b0;
    end else begin
      mem_rsp_valid <= mem_rd_valid && mem_rd_ready;
      mem_rsp_data  <= lmem[mem_rd_addr];
      if (mem_wr_valid && mem_wr_ready) lmem[mem_wr_addr] <= mem_wr_data;
      if (bank_rd_en) bank_rd_data <= bmem[work_bank][bank_rd_addr];
      if (bank_wr_en) bmem[work_bank][bank_wr_addr] <= bank_wr_data;
      if (fill_now) for (int i = 0; i < N; i++) bmem[0][packi(i)] <= hval(i);
    end
  end

  // Per-event monitor, sampled at the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wr_valid && mem_wr_ready) begin
        chk(mem_wr_addr == MAW'(cur_sb + wr_cnt), "R3 store address", mem_wr_addr, cur_sb + wr_cnt);
        chk(mem_wr_data == store_exp(wr_cnt), "R3 store data", mem_wr_data, store_exp(wr_cnt));
        wr_cnt++;
        last_wacc_cyc = cyc;
      end
      if (mem_rd_valid && mem_rd_ready) begin
        chk(mem_rd_addr == MAW'(cur_lb + rd_cnt), "R4 reload address", mem_rd_addr, cur_lb + rd_cnt);
        chk(wr_cnt == exp_wr, "R5 reload before store end", wr_cnt, exp_wr);
        rd_cnt++;
      end
      if (bank_wr_en) begin
        chk(bank_wr_addr == BAW'(packi(bwr_cnt)), "R4 bank address", bank_wr_addr, packi(bwr_cnt));
        chk(bank_wr_data == fval(cur_lb + bwr_cnt), "R4 bank data", bank_wr_data, fval(cur_lb + bwr_cnt));
        bwr_cnt++;
        last_bwr_cyc = cyc;
      end
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
      end
    end
  end

  task automatic run_step(input bit ss, input bit sl, input int sb, input int lb, input int knd,
                          input bit fast, input bit poke, input bit exp_bank, output int s_cyc);
    @(negedge clk);
    fast_mode = fast;
    cur_sb = sb; cur_lb = lb; kind = knd; exp_wr = ss ? 0 : N;
    wr_cnt = 0; rd_cnt = 0; bwr_cnt = 0; done_cnt = 0;
    done_cyc = -1; last_bwr_cyc = -1; last_wacc_cyc = -1;
    skip_store = ss; skip_load = sl;
    store_base = MAW'(sb); load_base = MAW'(lb);
    start = 1'b1;
    s_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      start = 1'b1; skip_store = 1'b1; skip_load = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(work_bank == exp_bank, "R2 start while busy toggled bank", work_bank, exp_bank);
    end
    for (int t = 0; t < 3000 && done_cnt == 0; t++) @(negedge clk);
    if (done_cnt == 0) chk(1'b0, "R7 step watchdog", 0, 1);
    repeat (6) @(negedge clk);
    chk(work_bank == exp_bank, "R2 work bank", work_bank, exp_bank);
    chk(done_cnt == 1, "R7 done pulse count", done_cnt, 1);
    chk(wr_cnt == (ss ? 0 : N), "R6 store word count", wr_cnt, ss ? 0 : N);
    chk(rd_cnt == (sl ? 0 : N), "R6 reload request count", rd_cnt, sl ? 0 : N);
    chk(bwr_cnt == (sl ? 0 : N), "R6 bank write count", bwr_cnt, sl ? 0 : N);
    if (!sl)      chk(done_cyc == last_bwr_cyc + 1, "R7 done after bank write", done_cyc, last_bwr_cyc + 1);
    else if (!ss) chk(done_cyc == last_wacc_cyc + 1, "R7 done after store", done_cyc, last_wacc_cyc + 1);
    else          chk(done_cyc == s_cyc + 1, "R7 done after start", done_cyc, s_cyc + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R7 global watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int sc;
    rst_n = 1'b0; start = 1'b0; skip_store = 1'b0; skip_load = 1'b0;
    store_base = '0; load_base = '0;
    mem_wr_ready = 1'b0; mem_rd_ready = 1'b0;
    repeat (4) @(negedge clk);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    chk(work_bank == 1'b0, "R1 bank in reset", work_bank, 0);
    chk(!mem_wr_valid && !mem_rd_valid, "R1 requests in reset", {mem_wr_valid, mem_rd_valid}, 0);
    chk(!bank_rd_en && !bank_wr_en, "R1 bank enables in reset", {bank_rd_en, bank_wr_en}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // A: first step, reload only, ready always high.
    run_step(1'b1, 1'b0, 0, 0, 0, 1'b1, 1'b0, 1'b1, sc);
    chk(done_cyc == sc + N + 2, "R9 reload-only latency", done_cyc, sc + N + 2);
    for (int i = 0; i < N; i++)
      chk(bmem[1][packi(i)] == fval(i), "R4 bank contents after reload", bmem[1][packi(i)], fval(i));

    // Compute side fills bank 0 with known partial sums.
    @(negedge clk); fill_now = 1'b1;
    @(negedge clk); fill_now = 1'b0;

    // B: full step with random back-pressure and an ignored start.
    run_step(1'b0, 1'b0, 100, 24, 0, 1'b0, 1'b1, 1'b0, sc);
    for (int i = 0; i < N; i++)
      chk(lmem[100 + i] == hval(i), "R3 stored tile", lmem[100 + i], hval(i));
    for (int i = 0; i < N; i++)
      chk(bmem[0][packi(i)] == fval(24 + i), "R4 reloaded tile", bmem[0][packi(i)], fval(24 + i));

    // C: last step, store only, ready always high.
    run_step(1'b0, 1'b1, 150, 60, 1, 1'b1, 1'b0, 1'b1, sc);
    chk(done_cyc == sc + 2 * N + 2, "R9 store-only latency", done_cyc, sc + 2 * N + 2);
    for (int i = 0; i < N; i++)
      chk(lmem[150 + i] == fval(i), "R3 stored tile C", lmem[150 + i], fval(i));
    for (int i = 0; i < N; i++)
      chk(bmem[1][packi(i)] == fval(i), "R6 bank untouched when reload skipped", bmem[1][packi(i)], fval(i));

    // D: final flush with back-pressure.
    run_step(1'b0, 1'b1, 200, 60, 2, 1'b0, 1'b0, 1'b0, sc);
    for (int i = 0; i < N; i++)
      chk(lmem[200 + i] == fval(24 + i), "R3 flushed tile", lmem[200 + i], fval(24 + i));

    // E: both phases skipped.
    run_step(1'b1, 1'b1, 0, 0, 0, 1'b1, 1'b0, 1'b1, sc);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule